// File: doc/BRIEF.md
# Oversampled Serial Receiver with Line-Break Recognition

This block receives asynchronous serial characters on a single line, using an external 16x sample tick to time the bits. A character is one low start bit, eight data bits sent least significant bit first, an optional even-parity bit and one stop bit. Each good or mis-framed character is delivered on `byte_o` with a one-cycle `rdy_o` strobe. Parity and framing problems are reported on sticky flags.

The receiver also recognises a line break, which is a character in which every data bit, the parity bit (when enabled) and the stop bit sample low. Such a character is not delivered as data and does not raise the framing flag. Instead it sets a sticky break flag. The receiver then waits for the line to return high for two consecutive 16x samples. That end of break sets the break flag again, and only then is a new start bit searched for. A one-cycle `sts_clr_i` pulse clears all three sticky flags.

States and transitions: `S_IDLE` goes to `S_START` when a tick samples the line low. `S_START` goes to `S_DATA` if the line is still low at its midpoint (8 ticks later); otherwise it returns to `S_IDLE` as a glitch. `S_DATA` takes eight bits, one every 16 ticks, and then goes to `S_PAR` if parity is enabled or to `S_STOP` if not. `S_PAR` goes to `S_STOP` after one bit. `S_STOP` goes to `S_IDLE` on a high stop bit or on a framing error, and to `S_BRKW` on a break. `S_BRKW` goes to `S_IDLE` when the end of break is seen.

Top module: `serial_brk_rx`

## Requirements
- R1: After reset, `rdy_o`, `par_err_o`, `frm_err_o` and `brk_o` are 0.
- R2: A low line seen on a tick is taken as a start bit only if the line is still low 8 ticks later; otherwise nothing is received and no strobe is produced.
- R3: Data bits are sampled every 16 ticks from the start-bit midpoint, first bit into bit 0. When the stop bit samples high, `byte_o` carries the character during a single-cycle `rdy_o` pulse.
- R4: With `par_en_i`=1, one parity bit follows the data. If the XOR of the eight data bits and the parity bit is 1, `par_err_o` is set and stays set.
- R5: A low stop bit in a character whose data and parity bits are not all 0 sets the sticky `frm_err_o` and still delivers the character with `rdy_o`.
- R6: A character whose data bits, parity bit (when enabled) and stop bit all sample 0 is a break. It sets `brk_o`, leaves `frm_err_o` unchanged and produces no `rdy_o`.
- R7: After a break, no new character is started while the line stays low. A single high sample does not end the break.
- R8: The line sampling high on 2 consecutive ticks ends the break. This sets `brk_o` and returns the receiver to searching for a start bit.
- R9: A pulse on `sts_clr_i` clears `brk_o`, `frm_err_o` and `par_err_o`. They stay set otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial line, idle high |
| os_tick_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| par_en_i | input | 1 | 1 = an even-parity bit follows the data |
| sts_clr_i | input | 1 | Pulse that clears the sticky flags |
| rdy_o | output | 1 | One-cycle strobe, `byte_o` valid |
| byte_o | output | 8 | Received character |
| par_err_o | output | 1 | Sticky parity error |
| frm_err_o | output | 1 | Sticky framing error |
| brk_o | output | 1 | Sticky break status |

## Verification
The receiver is driven with ordinary characters with and without parity, and with a correct and a wrong parity bit, which separates data delivery from parity checking. A character with a low stop bit and non-zero data is set against an all-zero character with a low stop bit. A zero-data character whose parity bit is high and whose stop bit is low is also used. These three show whether framing errors and breaks are told apart on every bit, not only on the stop bit. Inside the break, the line is held low and then given a single high sample, which shows that neither starts a new character nor ends the break. A two-sample high level then ends the break, and a following character is received. A short start glitch checks the midpoint rejection.

// File: rtl/serial_brk_pkg.sv
package serial_brk_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_BRKW
    } rx_state_t;
endpackage

// File: rtl/sbr_phase.sv
module sbr_phase #(
    parameter int OS_RATE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic restart_i,
    output logic half_o,
    output logic full_o
);
    localparam int CW = $clog2(OS_RATE);
    localparam logic [CW-1:0] HALF_V = CW'(OS_RATE / 2 - 1);
    localparam logic [CW-1:0] FULL_V = CW'(OS_RATE - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart_i)
            cnt <= '0;
        else if (tick_i)
            cnt <= (cnt == FULL_V) ? '0 : cnt + 1'b1;
    end

    assign half_o = tick_i && (cnt == HALF_V);
    assign full_o = tick_i && (cnt == FULL_V);
endmodule

// File: rtl/sbr_shift.sv
module sbr_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] data_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            data_o <= '0;
        else if (shift_i)
            data_o <= {bit_i, data_o[W-1:1]};
    end
endmodule

// File: rtl/sbr_endbrk.sv
module sbr_endbrk #(
    parameter int END_HI = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic tick_i,
    input  logic line_i,
    output logic done_o
);
    localparam int HW = $clog2(END_HI + 1);
    localparam logic [HW-1:0] LAST_V = HW'(END_HI - 1);

    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hi_cnt <= '0;
        else if (!arm_i)
            hi_cnt <= '0;
        else if (tick_i)
            hi_cnt <= line_i ? ((hi_cnt == LAST_V) ? hi_cnt : hi_cnt + 1'b1) : '0;
    end

    assign done_o = arm_i && tick_i && line_i && (hi_cnt >= LAST_V);
endmodule

// File: rtl/serial_brk_rx.sv
module serial_brk_rx
    import serial_brk_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int OS_RATE = 16,
    parameter int END_HI  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_i,
    input  logic              os_tick_i,
    input  logic              par_en_i,
    input  logic              sts_clr_i,
    output logic              rdy_o,
    output logic [DATA_W-1:0] byte_o,
    output logic              par_err_o,
    output logic              frm_err_o,
    output logic              brk_o
);
    localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(DATA_W - 1);

    rx_state_t         state, nxt;
    logic              half_hit, full_hit, restart, shift, end_brk;
    logic [DATA_W-1:0] sh_data;
    logic [IW-1:0]     bit_idx;
    logic              par_bit;
    logic              ev_ok, ev_frm, ev_brk;

    sbr_phase #(.OS_RATE(OS_RATE)) u_phase (
        .clk(clk), .rst_n(rst_n), .tick_i(os_tick_i), .restart_i(restart),
        .half_o(half_hit), .full_o(full_hit)
    );

    sbr_shift #(.W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_i(shift), .bit_i(rx_i), .data_o(sh_data)
    );

    sbr_endbrk #(.END_HI(END_HI)) u_endbrk (
        .clk(clk), .rst_n(rst_n), .arm_i(state == S_BRKW), .tick_i(os_tick_i),
        .line_i(rx_i), .done_o(end_brk)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= nxt;
    end

    // next state and frame events
    always_comb begin
        nxt     = state;
        restart = 1'b0;
        shift   = 1'b0;
        ev_ok   = 1'b0;
        ev_frm  = 1'b0;
        ev_brk  = 1'b0;
        unique case (state)
            S_IDLE: if (os_tick_i && !rx_i) begin
                nxt     = S_START;
                restart = 1'b1;
            end
            S_START: if (half_hit) begin
                restart = 1'b1;
                nxt     = rx_i ? S_IDLE : S_DATA;
            end
            S_DATA: if (full_hit) begin
                shift = 1'b1;
                if (bit_idx == LAST_IDX)
                    nxt = par_en_i ? S_PAR : S_STOP;
            end
            S_PAR: if (full_hit)
                nxt = S_STOP;
            S_STOP: if (full_hit) begin
                if (rx_i) begin
                    ev_ok = 1'b1;
                    nxt   = S_IDLE;
                end else if ((sh_data == '0) && !par_bit) begin
                    ev_brk = 1'b1;
                    nxt    = S_BRKW;
                end else begin
                    ev_frm = 1'b1;
                    nxt    = S_IDLE;
                end
            end
            S_BRKW: if (end_brk)
                nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // bit index and parity capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx <= '0;
            par_bit <= 1'b0;
        end else if (state == S_START) begin
            bit_idx <= '0;
            par_bit <= 1'b0;
        end else begin
            if (shift)
                bit_idx <= bit_idx + 1'b1;
            if (state == S_PAR && full_hit)
                par_bit <= rx_i;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy_o     <= 1'b0;
            byte_o    <= '0;
            par_err_o <= 1'b0;
            frm_err_o <= 1'b0;
            brk_o     <= 1'b0;
        end else begin
            rdy_o <= ev_ok || ev_frm;
            if (ev_ok || ev_frm)
                byte_o <= sh_data;
            if ((ev_ok || ev_frm) && par_en_i && ((^sh_data) ^ par_bit))
                par_err_o <= 1'b1;
            else if (sts_clr_i)
                par_err_o <= 1'b0;
            if (ev_frm)
                frm_err_o <= 1'b1;
            else if (sts_clr_i)
                frm_err_o <= 1'b0;
            if (ev_brk || end_brk)
                brk_o <= 1'b1;
            else if (sts_clr_i)
                brk_o <= 1'b0;
        end
    end

    // R3: strobe lasts one cycle
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o |=> !rdy_o);
    // R3: strobe only follows a stop-bit sample
    a_r3_strobe_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o |-> $past(state) == S_STOP);
    // R5: framing error always comes with data
    a_r5_frm_delivers: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frm_err_o) |-> rdy_o);
    // R6: no strobe while in a break
    a_r6_no_strobe_in_break: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BRKW) |-> !rdy_o);
    // R6: entering a break never raises the framing flag
    a_r6_brk_not_frm: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BRKW && $past(state) == S_STOP) |-> !$rose(frm_err_o));
    // R7: a low line keeps the receiver waiting
    a_r7_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BRKW && !rx_i) |=> state == S_BRKW);
    // R9: break flag is sticky
    a_r9_brk_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_o && !sts_clr_i) |=> brk_o);
endmodule

// File: tb/sim_serial_brk_rx.sv
module sim_serial_brk_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_i = 1'b1;
    logic       os_tick_i = 1'b0;
    logic       par_en_i = 1'b0;
    logic       sts_clr_i = 1'b0;
    logic       rdy_o;
    logic [7:0] byte_o;
    logic       par_err_o, frm_err_o, brk_o;

    int checks = 0;
    int errors = 0;
    int rdy_cnt = 0;
    logic [7:0] last_byte = 8'h00;

    serial_brk_rx u0 (
        .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .os_tick_i(os_tick_i),
        .par_en_i(par_en_i), .sts_clr_i(sts_clr_i), .rdy_o(rdy_o),
        .byte_o(byte_o), .par_err_o(par_err_o), .frm_err_o(frm_err_o),
        .brk_o(brk_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) os_tick_i <= ~os_tick_i;

    always @(negedge clk) if (rst_n && rdy_o) begin
        rdy_cnt   = rdy_cnt + 1;
        last_byte = byte_o;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input logic b, input int ticks);
        rx_i = b;
        repeat (2 * ticks) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic use_par, input logic pb,
                        input logic stopb);
        hold(1'b0, 16);
        for (int i = 0; i < 8; i++) hold(d[i], 16);
        if (use_par) hold(pb, 16);
        hold(stopb, 16);
        hold(1'b1, 32);
    endtask

    task automatic clr_pulse();
        @(negedge clk) sts_clr_i = 1'b1;
        @(negedge clk) sts_clr_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 rdy", int'(rdy_o), 0);
        chk("R1 brk", int'(brk_o), 0);
        chk("R1 frm", int'(frm_err_o), 0);
        chk("R1 par", int'(par_err_o), 0);
    endtask

    task automatic t_plain();
        int n0 = rdy_cnt;
        par_en_i = 1'b0;
        send(8'hA5, 1'b0, 1'b0, 1'b1);
        chk("R3 count", rdy_cnt - n0, 1);
        chk("R3 data", int'(last_byte), 8'hA5);
        send(8'h01, 1'b0, 1'b0, 1'b1);
        chk("R3 lsb first", int'(last_byte), 8'h01);
        chk("R5 no frm", int'(frm_err_o), 0);
    endtask

    task automatic t_parity();
        par_en_i = 1'b1;
        send(8'h3C, 1'b1, 1'b0, 1'b1);
        chk("R4 good data", int'(last_byte), 8'h3C);
        chk("R4 good par", int'(par_err_o), 0);
        send(8'h3C, 1'b1, 1'b1, 1'b1);
        chk("R4 bad par", int'(par_err_o), 1);
        send(8'h07, 1'b1, 1'b1, 1'b1);
        chk("R4 sticky", int'(par_err_o), 1);
        clr_pulse();
        chk("R9 par clr", int'(par_err_o), 0);
        par_en_i = 1'b0;
    endtask

    task automatic t_frame();
        int n0 = rdy_cnt;
        send(8'h81, 1'b0, 1'b0, 1'b0);
        chk("R5 frm", int'(frm_err_o), 1);
        chk("R5 data", int'(last_byte), 8'h81);
        chk("R5 count", rdy_cnt - n0, 1);
        chk("R6 no brk on frm", int'(brk_o), 0);
        n0 = rdy_cnt;
        par_en_i = 1'b1;
        send(8'h00, 1'b1, 1'b1, 1'b0);
        chk("R5 zero data par hi brk", int'(brk_o), 0);
        chk("R5 zero data par hi count", rdy_cnt - n0, 1);
        chk("R4 zero data par hi", int'(par_err_o), 1);
        par_en_i = 1'b0;
        clr_pulse();
        chk("R9 frm clr", int'(frm_err_o), 0);
    endtask

    task automatic t_glitch();
        int n0 = rdy_cnt;
        hold(1'b0, 4);
        hold(1'b1, 40);
        chk("R2 glitch", rdy_cnt - n0, 0);
        send(8'h96, 1'b0, 1'b0, 1'b1);
        chk("R2 after glitch", int'(last_byte), 8'h96);
    endtask

    task automatic t_break(input logic use_par);
        int n0 = rdy_cnt;
        par_en_i = use_par;
        hold(1'b0, 16 * 13);
        chk("R6 brk set", int'(brk_o), 1);
        chk("R6 no frm", int'(frm_err_o), 0);
        chk("R6 no rdy", rdy_cnt - n0, 0);
        clr_pulse();
        chk("R9 brk clr", int'(brk_o), 0);
        hold(1'b0, 16 * 12);
        chk("R7 low no rdy", rdy_cnt - n0, 0);
        hold(1'b1, 1);
        hold(1'b0, 16 * 2);
        chk("R7 one sample", int'(brk_o), 0);
        hold(1'b1, 16);
        chk("R8 end brk", int'(brk_o), 1);
        clr_pulse();
        send(8'h5A, use_par, 1'b0, 1'b1);
        chk("R8 resume", int'(last_byte), 8'h5A);
        chk("R8 resume count", rdy_cnt - n0, 1);
        chk("R9 stays clear", int'(brk_o), 0);
        par_en_i = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        hold(1'b1, 20);
        t_plain();
        t_parity();
        t_frame();
        t_glitch();
        t_break(1'b0);
        t_break(1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule